// File: doc/BRIEF.md
# Walking-Zero Stimulus Generator

This block produces a sequence of test words for a wide AND structure so that transition hazards in that structure can be exposed. Each presented word comes with a valid strobe and a flag that gives the value a correct AND of the word must take. A start command launches one of two sequences, and the sequence advances only in cycles where the step-enable input is high.

The sweep sequence frames a single zero that walks across the word between all-zero and all-ones words. The pair sequence exercises every direct jump between two single-zero words. It first loads the word with the zero at the lower position, then jumps straight to the word with the zero at the higher position, with no word in between that has both zeros. An internal comparator registers the AND of each presented word and checks it against the expected flag one cycle later. Any mismatch sets a sticky error output.

Top module: `wz_walk_gen`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `stimulus` is all zeros, and `stimValid`, `expectAnd`, `done` and `cmpError` are all 0.
- R2: Sweep mode (`modeSel` = 0 at start) presents WIDTH+4 words in this order: all zeros, all ones, then WIDTH words with the single zero at bit 0, bit 1, and so on up to bit WIDTH-1, then all ones, then all zeros.
- R3: Each walking word of the sweep has exactly one bit at 0 and every other bit at 1. No presented word in either mode has more than one zero, unless it is the all-zeros word.
- R4: Pair mode (`modeSel` = 1 at start) visits the position pairs (i, j) with i < j, with i as the outer ascending loop and j as the inner ascending loop. For each pair it presents the word with the single zero at bit i and then the word with the single zero at bit j.
- R5: Pair mode performs exactly WIDTH*(WIDTH-1)/2 jumps, which is 276 for WIDTH = 24, so it presents twice that many words.
- R6: `expectAnd` is 1 with a presented word exactly when that word is all ones.
- R7: The sequence advances by one word at each clock edge where `stepEn` is high. `stimValid` is high in the cycle after each such edge and low in every other cycle, and `stimulus` holds its value while `stimValid` is low.
- R8: `done` is high for exactly one cycle. That cycle directly follows the cycle that presents the final word, whatever `stepEn` does. Afterwards no word is presented until the next start.
- R9: The mode is captured when a start is accepted. A start that arrives while a sequence is running is ignored and does not change the sequence or the mode.
- R10: `cmpError` becomes 1 and stays 1 until reset if the AND of a presented word, registered one cycle later, differs from that word's `expectAnd`. On a correct sequence it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a sequence when the generator is idle |
| modeSel | input | 1 | Selects the sequence at start: 0 sweep, 1 pairs |
| stepEn | input | 1 | Lets the sequence advance one word at this edge |
| stimulus | output | WIDTH | Test word driven into the AND under test |
| stimValid | output | 1 | High in each cycle that presents a new word |
| expectAnd | output | 1 | Correct AND value of the presented word |
| done | output | 1 | One-cycle pulse after the final word |
| cmpError | output | 1 | Sticky mismatch between registered AND and expected flag |

## Verification
Two situations are hard to reach from the ports. The first is the last jump of the pair sequence, from the zero at WIDTH-2 to the zero at WIDTH-1, which must be followed directly by `done`. The second is a start pulse that lands partway through a running sequence with the opposite mode on `modeSel`. The bench reaches both by running complete 552-word pair sequences and complete sweeps at full WIDTH. It uses both continuous and gapped step-enable patterns, and it injects a conflicting start a few words into chosen runs. Every word is compared against a list built arithmetically in the bench, and the number of words seen before `done` is counted.

// File: rtl/wz_pkg.sv
package wz_pkg;

  typedef enum logic [1:0] {
    PAT_ZEROS  = 2'd0,
    PAT_ONES   = 2'd1,
    PAT_SINGLE = 2'd2
  } patKind_e;

  typedef enum logic {
    MODE_SWEEP = 1'b0,
    MODE_PAIRS = 1'b1
  } seqMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;    // present a new word this edge
    patKind_e kind;    // shape of that word
    logic     finish;  // sequence complete, raise done
  } ctrlStrobe_t;

endpackage

// File: rtl/wz_ctrl.sv
module wz_ctrl
  import wz_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      modeSel,
  input  logic                      stepEn,
  output ctrlStrobe_t               strobe,
  output logic [$clog2(WIDTH)-1:0]  zeroPos
);

  localparam int IDXW = $clog2(WIDTH);
  localparam int CNTW = $clog2(WIDTH + 4);
  localparam logic [CNTW-1:0] CNT_ONES_A = CNTW'(1);
  localparam logic [CNTW-1:0] CNT_WALK_E = CNTW'(WIDTH + 1);
  localparam logic [CNTW-1:0] CNT_ONES_B = CNTW'(WIDTH + 2);
  localparam logic [IDXW-1:0] POS_LAST   = IDXW'(WIDTH - 1);
  localparam logic [IDXW-1:0] POS_PENULT = IDXW'(WIDTH - 2);

  seqState_e        state;
  seqMode_e         mode;
  logic [CNTW-1:0]  stepCnt;
  logic [IDXW-1:0]  posI;
  logic [IDXW-1:0]  posJ;
  logic             jumpPhase;
  logic             lastStep;
  logic             doStep;

  assign doStep = (state == ST_RUN) && stepEn;

  always_comb begin
    strobe        = '0;
    strobe.kind   = PAT_ZEROS;
    strobe.finish = (state == ST_FIN);
    zeroPos       = '0;
    lastStep      = 1'b0;
    if (doStep) begin
      strobe.load = 1'b1;
      if (mode == MODE_SWEEP) begin
        if (stepCnt == '0) begin
          strobe.kind = PAT_ZEROS;
        end else if (stepCnt == CNT_ONES_A) begin
          strobe.kind = PAT_ONES;
        end else if (stepCnt <= CNT_WALK_E) begin
          strobe.kind = PAT_SINGLE;
          zeroPos     = IDXW'(stepCnt - CNTW'(2));
        end else if (stepCnt == CNT_ONES_B) begin
          strobe.kind = PAT_ONES;
        end else begin
          strobe.kind = PAT_ZEROS;
          lastStep    = 1'b1;
        end
      end else begin
        strobe.kind = PAT_SINGLE;
        zeroPos     = jumpPhase ? posJ : posI;
        lastStep    = jumpPhase && (posI == POS_PENULT) && (posJ == POS_LAST);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode      <= MODE_SWEEP;
      stepCnt   <= '0;
      posI      <= '0;
      posJ      <= '0;
      jumpPhase <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_RUN;
            mode      <= seqMode_e'(modeSel);
            stepCnt   <= '0;
            posI      <= '0;
            posJ      <= IDXW'(1);
            jumpPhase <= 1'b0;
          end
        end
        ST_RUN: begin
          if (doStep) begin
            if (lastStep) begin
              state <= ST_FIN;
            end else if (mode == MODE_SWEEP) begin
              stepCnt <= stepCnt + CNTW'(1);
            end else if (!jumpPhase) begin
              jumpPhase <= 1'b1;
            end else begin
              jumpPhase <= 1'b0;
              if (posJ == POS_LAST) begin
                posI <= posI + IDXW'(1);
                posJ <= posI + IDXW'(2);
              end else begin
                posJ <= posJ + IDXW'(1);
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wz_datapath.sv
module wz_datapath
  import wz_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrlStrobe_t               strobe,
  input  logic [$clog2(WIDTH)-1:0]  zeroPos,
  output logic [WIDTH-1:0]          stimulus,
  output logic                      stimValid,
  output logic                      expectAnd,
  output logic                      done,
  output logic                      cmpError
);

  localparam int IDXW = $clog2(WIDTH);

  logic [WIDTH-1:0] singleWord;
  logic [WIDTH-1:0] nextWord;
  logic             andDly;
  logic             expDly;
  logic             valDly;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign singleWord[b] = (zeroPos != IDXW'(b));
  end

  always_comb begin
    case (strobe.kind)
      PAT_ONES:   nextWord = '1;
      PAT_SINGLE: nextWord = singleWord;
      default:    nextWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stimulus  <= '0;
      stimValid <= 1'b0;
      expectAnd <= 1'b0;
      done      <= 1'b0;
    end else begin
      stimValid <= strobe.load;
      done      <= strobe.finish;
      if (strobe.load) begin
        stimulus  <= nextWord;
        expectAnd <= (strobe.kind == PAT_ONES);
      end
    end
  end

  // registered AND of the presented word against its expected flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      andDly   <= 1'b0;
      expDly   <= 1'b0;
      valDly   <= 1'b0;
      cmpError <= 1'b0;
    end else begin
      andDly <= &stimulus;
      expDly <= expectAnd;
      valDly <= stimValid;
      if (valDly && (andDly != expDly)) begin
        cmpError <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wz_walk_gen.sv
module wz_walk_gen
  import wz_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             modeSel,
  input  logic             stepEn,
  output logic [WIDTH-1:0] stimulus,
  output logic             stimValid,
  output logic             expectAnd,
  output logic             done,
  output logic             cmpError
);

  ctrlStrobe_t                strobe;
  logic [$clog2(WIDTH)-1:0]   zeroPos;

  wz_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .modeSel (modeSel),
    .stepEn  (stepEn),
    .strobe  (strobe),
    .zeroPos (zeroPos)
  );

  wz_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .zeroPos   (zeroPos),
    .stimulus  (stimulus),
    .stimValid (stimValid),
    .expectAnd (expectAnd),
    .done      (done),
    .cmpError  (cmpError)
  );

endmodule

// File: rtl/wz_walk_gen_chk.sv
module wz_walk_gen_chk #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stepEn,
  input logic [WIDTH-1:0] stimulus,
  input logic             stimValid,
  input logic             expectAnd,
  input logic             done,
  input logic             cmpError
);

  assert_ones_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stimValid && expectAnd) |-> (&stimulus));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stimValid && !expectAnd) |-> !(&stimulus));

  assert_single_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stimValid |-> (($countones(~stimulus) <= 1) || (stimulus == '0)));

  assert_step_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stimValid |-> $past(stepEn));

  assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stimValid |-> $stable(stimulus));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stimValid);

  assert_no_mismatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpError);

endmodule

bind wz_walk_gen wz_walk_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stepEn    (stepEn),
  .stimulus  (stimulus),
  .stimValid (stimValid),
  .expectAnd (expectAnd),
  .done      (done),
  .cmpError  (cmpError)
);

// File: tb/tb_wz_walk_gen.sv
module tb_wz_walk_gen;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         modeSel = 1'b0;
  logic         stepEn = 1'b0;
  logic [W-1:0] stimulus;
  logic         stimValid;
  logic         expectAnd;
  logic         done;
  logic         cmpError;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [W-1:0] expQ[$];

  always #2 clk = ~clk;

  wz_walk_gen #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .modeSel(modeSel), .stepEn(stepEn),
    .stimulus(stimulus), .stimValid(stimValid), .expectAnd(expectAnd),
    .done(done), .cmpError(cmpError)
  );

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic buildSweep();
    expQ.delete();
    expQ.push_back('0);
    expQ.push_back('1);
    for (int k = 0; k < W; k++) expQ.push_back(~(W'(1) << k));
    expQ.push_back('1);
    expQ.push_back('0);
  endtask

  task automatic buildPairs();
    expQ.delete();
    for (int i = 0; i < W; i++)
      for (int j = i + 1; j < W; j++) begin
        expQ.push_back(~(W'(1) << i));
        expQ.push_back(~(W'(1) << j));
      end
  endtask

  // gap = 0 keeps stepEn high; otherwise every gap-th cycle is idle
  task automatic runSeq(bit mode, int gap, int injectAt);
    int idx = 0;
    int cyc = 0;
    bit prevStep = 1'b0;
    bit sawDone = 1'b0;
    bit injected = 1'b0;
    logic [W-1:0] lastStim;
    string reqTag;
    int n;
    if (mode) buildPairs(); else buildSweep();
    reqTag = mode ? "R4" : "R2";
    n = expQ.size();
    @(negedge clk);
    start = 1'b1; modeSel = mode; stepEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    lastStim = stimulus;
    while (!sawDone && cyc < 5000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (done) begin
        sawDone = 1'b1;
        check(mode ? "R5" : "R8", "words before done", W'(idx), W'(n));
        check("R8", "valid with done", W'(stimValid), W'(0));
      end else if (idx >= n) begin
        check("R8", "done after final word", W'(done), W'(1));
        sawDone = 1'b1;
      end else if (prevStep) begin
        check("R7", "valid after step", W'(stimValid), W'(1));
        check(reqTag, "word order", stimulus, expQ[idx]);
        check("R6", "expected AND flag", W'(expectAnd), W'(expQ[idx] == '1));
        if (!mode && idx >= 2 && idx < W + 2)
          check("R3", "zero count", W'($countones(~stimulus)), W'(1));
        idx++;
        lastStim = stimulus;
      end else begin
        check("R7", "valid without step", W'(stimValid), W'(0));
        check("R7", "word held", stimulus, lastStim);
      end
      start = 1'b0;
      if (injectAt >= 0 && idx == injectAt && !injected) begin
        injected = 1'b1;
        start = 1'b1;
        modeSel = ~mode;  // R9: must be ignored mid-run
      end
      stepEn = (gap == 0) ? 1'b1 : ((cyc % gap) != 0);
      prevStep = stepEn;
    end
    start = 1'b0;
    @(negedge clk);
    check("R8", "done single pulse", W'(done), W'(0));
    stepEn = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R8", "idle after done", W'(stimValid), W'(0));
    end
    stepEn = 1'b0;
    check("R10", "comparator error", W'(cmpError), W'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset word", stimulus, '0);
    check("R1", "reset valid", W'(stimValid), W'(0));
    check("R1", "reset flag", W'(expectAnd), W'(0));
    check("R1", "reset done", W'(done), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset word", stimulus, '0);
    check("R1", "post-reset valid", W'(stimValid), W'(0));
    check("R1", "post-reset error", W'(cmpError), W'(0));
    runSeq(1'b0, 0, -1);
    runSeq(1'b0, 3, 4);   // R9 conflicting start during sweep
    runSeq(1'b1, 0, 5);   // R9 conflicting start during pairs
    runSeq(1'b1, 2, -1);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule